// File: doc/BRIEF.md
# Program Counter and Circular Return Stack

This block sequences instruction fetch for a small 14-bit-instruction controller core. It holds a 13-bit program counter, steps it once per instruction, and redirects it on jumps, subroutine calls, returns, interrupt entry and direct writes of the counter's low byte. An 8-deep return stack stores full 13-bit return addresses. Software cannot read the stack or address its pointer.

A jump or call carries only an 11-bit target. The two page bits above it come from an external 5-bit holding latch, and the same latch supplies the whole upper part of the counter when software writes the low byte. The stack never reports overflow or underflow. Its pointer wraps modulo the depth, so extra pushes overwrite the oldest entries and extra pops return whatever entry the pointer lands on. Only 4K words of the 8K address space exist, so the fetch address is the counter's low 12 bits.

Top module: `pc_seq`

## Requirements
- R1: While reset is asserted the counter loads 0000h and the stack pointer and all stack entries clear. A return issued right after reset therefore yields 0000h.
- R2: When only `step` is asserted, the counter increments by one modulo 2^13, so 1FFFh steps to 0000h. `fetch_addr` always equals the counter's bits 11:0, so counters 1000h and 0000h fetch the same word.
- R3: A jump loads the counter with `{hold_latch[4:3], jmp_tgt[10:0]}`.
- R4: A call pushes counter+1 onto the stack and loads the counter as a jump does.
- R5: A return loads the counter with the most recently pushed entry that has not been popped (last in, first out).
- R6: An interrupt entry pushes counter+1 and loads 0004h. It wins over a call, jump, return or low-byte write requested in the same cycle, and that other request has no effect.
- R7: The pointer is circular modulo 8. The ninth push overwrites the first entry and the tenth overwrites the second, and pops keep wrapping past empty without any error indication.
- R8: A low-byte write loads the counter with `{hold_latch[4:0], pcl_data[7:0]}`.
- R9: Among the other requests the priority is call, then jump, then return, then low-byte write, then step. With no request the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance to the next sequential instruction |
| goto_req | input | 1 | Jump to a paged target |
| call_req | input | 1 | Call: push the return address and jump |
| ret_req | input | 1 | Any return kind: pop into the counter |
| irq_take | input | 1 | Interrupt entry |
| pcl_wr | input | 1 | Write the counter low byte |
| jmp_tgt | input | 11 | Jump or call target within a page |
| pcl_data | input | 8 | Low byte value for a write |
| hold_latch | input | 5 | Upper-address holding latch value |
| pc_out | output | 13 | Current program counter |
| fetch_addr | output | 12 | Implemented program memory address |

## Verification
The hardest situation to reach is a stack that has wrapped. Its oldest entries have been overwritten and its later pops run past the real history. Only long unbroken chains of calls and returns reach it. The stimulus nests ten calls with distinct targets, unwinds with ten or more returns, and issues a return straight after reset. It then crosses interrupts with calls in the same cycle and runs a long random mix. A behavioural model with its own circular array checks every cycle.

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int PC_W    = 13,
  parameter int DEPTH   = 8,
  parameter int IMPL_W  = 12,
  parameter int JMP_W   = 11,
  parameter int DATA_W  = 8,
  parameter int IRQ_VEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              goto_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic              irq_take,
  input  logic              pcl_wr,
  input  logic [JMP_W-1:0]  jmp_tgt,
  input  logic [DATA_W-1:0] pcl_data,
  input  logic [PC_W-DATA_W-1:0] hold_latch,
  output logic [PC_W-1:0]   pc_out,
  output logic [IMPL_W-1:0] fetch_addr
);
  localparam int SP_W  = $clog2(DEPTH);
  localparam int PG_W  = PC_W - JMP_W;
  localparam int PG_LO = JMP_W - DATA_W;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [SP_W-1:0] sp_q;
  logic [PC_W-1:0] stk [DEPTH];

  wire [PC_W-1:0] pc_inc  = pc_q + PC_W'(1);
  wire [PC_W-1:0] jmp_pc  = {hold_latch[PG_LO +: PG_W], jmp_tgt};
  wire [SP_W-1:0] sp_top  = sp_q - SP_W'(1);
  wire            do_push = irq_take | call_req;
  wire            do_pop  = ret_req & ~irq_take & ~call_req & ~goto_req;

  always_comb begin
    pc_d = pc_q;
    if (irq_take)      pc_d = PC_W'(IRQ_VEC);
    else if (call_req) pc_d = jmp_pc;
    else if (goto_req) pc_d = jmp_pc;
    else if (ret_req)  pc_d = stk[sp_top];
    else if (pcl_wr)   pc_d = {hold_latch, pcl_data};
    else if (step)     pc_d = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      pc_q <= pc_d;
      if (do_push) begin
        stk[sp_q] <= pc_inc;
        sp_q      <= sp_q + SP_W'(1);
      end else if (do_pop) begin
        sp_q      <= sp_top;
      end
    end
  end

  assign pc_out     = pc_q;
  assign fetch_addr = pc_q[IMPL_W-1:0];
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int PC_W    = 13,
  parameter int JMP_W   = 11,
  parameter int DATA_W  = 8,
  parameter int IRQ_VEC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              goto_req,
  input logic              call_req,
  input logic              ret_req,
  input logic              irq_take,
  input logic              pcl_wr,
  input logic [JMP_W-1:0]  jmp_tgt,
  input logic [DATA_W-1:0] pcl_data,
  input logic [PC_W-DATA_W-1:0] hold_latch,
  input logic [PC_W-1:0]   pc_out
);
  localparam int PG_LO = JMP_W - DATA_W;
  wire only_step = step & ~goto_req & ~call_req & ~ret_req & ~irq_take & ~pcl_wr;
  wire only_goto = goto_req & ~call_req & ~irq_take;
  wire only_pcl  = pcl_wr & ~goto_req & ~call_req & ~ret_req & ~irq_take;

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc_out == '0);
  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_step |=> pc_out == $past(pc_out) + PC_W'(1));
  // R3
  goto_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_goto |=> pc_out == {$past(hold_latch[PG_LO +: PC_W-JMP_W]), $past(jmp_tgt)});
  // R6
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc_out == PC_W'(IRQ_VEC));
  // R8
  pcl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only_pcl |=> pc_out == {$past(hold_latch), $past(pcl_data)});
endmodule

bind pc_seq pc_seq_chk #(.PC_W(PC_W), .JMP_W(JMP_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .goto_req(goto_req), .call_req(call_req),
  .ret_req(ret_req), .irq_take(irq_take), .pcl_wr(pcl_wr), .jmp_tgt(jmp_tgt),
  .pcl_data(pcl_data), .hold_latch(hold_latch), .pc_out(pc_out));

// File: tb/tb_pc_seq.sv
`timescale 1ns/1ps
module tb_pc_seq;
  logic clk = 0, rst_n = 0;
  logic step = 0, goto_req = 0, call_req = 0, ret_req = 0, irq_take = 0, pcl_wr = 0;
  logic [10:0] jmp_tgt = '0;
  logic [7:0]  pcl_data = '0;
  logic [4:0]  hold_latch = '0;
  logic [12:0] pc_out;
  logic [11:0] fetch_addr;

  int compared = 0, mismatched = 0;
  int m_pc = 0, m_sp = 0;
  int m_stk [8];
  string tag = "R1";

  always #2 clk = ~clk;

  pc_seq dut (.clk(clk), .rst_n(rst_n), .step(step), .goto_req(goto_req), .call_req(call_req),
    .ret_req(ret_req), .irq_take(irq_take), .pcl_wr(pcl_wr), .jmp_tgt(jmp_tgt),
    .pcl_data(pcl_data), .hold_latch(hold_latch), .pc_out(pc_out), .fetch_addr(fetch_addr));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_sp = 0; tag = "R1";
      foreach (m_stk[i]) m_stk[i] = 0;
    end else if (irq_take) begin
      m_stk[m_sp] = (m_pc + 1) % 8192; m_sp = (m_sp + 1) % 8; m_pc = 4; tag = "R6";
    end else if (call_req) begin
      m_stk[m_sp] = (m_pc + 1) % 8192; m_sp = (m_sp + 1) % 8;
      m_pc = hold_latch[4:3] * 2048 + jmp_tgt; tag = "R4";
    end else if (goto_req) begin
      m_pc = hold_latch[4:3] * 2048 + jmp_tgt; tag = "R3";
    end else if (ret_req) begin
      m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; tag = "R5";
    end else if (pcl_wr) begin
      m_pc = hold_latch * 256 + pcl_data; tag = "R8";
    end else if (step) begin
      m_pc = (m_pc + 1) % 8192; tag = "R2";
    end else tag = "R9";
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(tag, pc_out, m_pc);
    check("R2", fetch_addr, m_pc % 4096);
  end

  task automatic idle();
    step = 0; goto_req = 0; call_req = 0; ret_req = 0; irq_take = 0; pcl_wr = 0;
  endtask

  task automatic cyc(bit s, bit g, bit c, bit r, bit i, bit w);
    @(negedge clk);
    step = s; goto_req = g; call_req = c; ret_req = r; irq_take = i; pcl_wr = w;
  endtask

  initial begin
    #200000;
    mismatched++; compared++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: return right after reset yields 0000h
    rst_n = 1; cyc(0,0,0,1,0,0);
    cyc(1,0,0,0,0,0); repeat (5) cyc(1,0,0,0,0,0);
    // R2: wrap 1FFF -> 0 and 12-bit fetch alias
    hold_latch = 5'h1F; pcl_data = 8'hFE; cyc(0,0,0,0,0,1);
    repeat (3) cyc(1,0,0,0,0,0);
    hold_latch = 5'h10; pcl_data = 8'h05; cyc(0,0,0,0,0,1);
    // R3: jumps on each page
    for (int p = 0; p < 4; p++) begin
      hold_latch = 5'(p * 8 + 3); jmp_tgt = 11'(p * 300 + 7); cyc(0,1,0,0,0,0);
    end
    // R7: ten nested calls then twelve returns
    for (int k = 0; k < 10; k++) begin
      hold_latch = 5'(k); jmp_tgt = 11'(k * 100 + 1); cyc(0,0,1,0,0,0); cyc(1,0,0,0,0,0);
    end
    for (int k = 0; k < 12; k++) cyc(0,0,0,1,0,0);
    // R6: interrupt wins over call, jump, return and write
    jmp_tgt = 11'h555; cyc(0,0,1,0,1,0); cyc(0,1,0,1,1,1); cyc(0,0,0,1,0,0); cyc(0,0,0,1,0,0);
    // R9: priority among others and hold
    cyc(0,1,1,1,0,1); cyc(1,1,0,1,0,1); cyc(1,0,0,1,0,1); cyc(1,0,0,0,0,1);
    cyc(0,0,0,0,0,0); cyc(0,0,0,0,0,0);
    // R5: mixed traffic
    for (int k = 0; k < 3000; k++) begin
      jmp_tgt = 11'($urandom); pcl_data = 8'($urandom); hold_latch = 5'($urandom);
      cyc($urandom_range(0,1) == 1, $urandom_range(0,7) == 0, $urandom_range(0,5) == 0,
          $urandom_range(0,4) == 0, $urandom_range(0,15) == 0, $urandom_range(0,11) == 0);
    end
    // R1: reset mid-run
    idle(); rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    cyc(0,0,0,1,0,0); cyc(1,0,0,0,0,0);
    @(negedge clk); idle(); @(negedge clk); @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule